// File: doc/BRIEF.md
# Thread-Aware LRU Replacement Selector for a 16-Way Shared Cache

This block tracks recency for every set of a 16-way cache shared by up to four hardware threads. For each set it also records which thread brought each resident block in. On a hit, the referenced way becomes the most recent one. On a miss, the block picks the way to refill. An invalid way is always taken first. Failing that, a block belonging to a thread that is no longer running is taken. Failing that, the block is taken from the thread that would hold the most blocks in the set once the new block arrives. This keeps a thread with a high miss rate from squeezing out the working set of a quieter neighbour.

A request carries:
- the set index;
- a hit flag with the hit way;
- the requesting thread;
- the tag array's valid bits for the set;
- a mask of inactive threads.

A small state machine handles one request at a time:
- ST_IDLE (ready): accepts a request and moves to ST_LOAD.
- ST_LOAD: latches the set's stack and moves to ST_CHOOSE.
- ST_CHOOSE: computes the victim and the reordered stack, then moves to ST_COMMIT.
- ST_COMMIT: presents the response for one cycle, writes the stack back, and returns to ST_IDLE.

Top module: `shlru_victim_sel`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. Every set's stack holds ways 0..15 from most to least recent, all owned by thread 0. So the first miss in a fresh set from thread 1 (all valid, none inactive) returns way 15 with owner 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `rsp_valid` is then high for exactly one cycle, the third cycle after acceptance. `req_ready` is 0 from acceptance until the cycle after the response.
- R3: On a hit the response returns the hit way, its current owner, and reason code 2'b00. The way becomes most recent and keeps its owner.
- R4: On a miss with any valid bit clear, the lowest-indexed invalid way is chosen. The response returns its recorded owner and reason code 2'b01.
- R5: Otherwise, if any resident block is owned by a thread whose `tid_inactive` bit (bit index = thread ID) is set, the response returns the inactive-owned block nearest the least-recent end, with reason code 2'b10. Inactive bits of threads owning no block in the set have no effect.
- R6: Otherwise, each thread's count is its resident blocks plus one for the requester. The response returns the least-recent block of the thread with the largest count, with reason code 2'b11.
- R7: When several threads share the largest count, the thread whose least-recent block sits closest to the least-recent end is chosen.
- R8: After a miss, the chosen way becomes most recent and is owned by the requester. The ways that were more recent than it each move one place toward the least-recent end.
- R9: Each set keeps its own stack. Requests to one set never change the choice made in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_set | input | 4 | Set index |
| req_hit | input | 1 | 1 = hit on `req_way`, 0 = miss |
| req_way | input | 4 | Hit way |
| req_tid | input | 2 | Requesting thread |
| way_valid | input | 16 | Valid bit per way of the set |
| tid_inactive | input | 4 | Bit per thread, 1 = thread not running |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_way | output | 4 | Hit way or chosen victim way |
| rsp_tid | output | 2 | Owner of `rsp_way` before the update |
| rsp_reason | output | 2 | 00 hit, 01 invalid, 10 inactive, 11 majority |

## Verification
A corrupted stack entry does not show up at once. It stays hidden until a later miss in the same set makes a choice that depends on the damaged slot. The bench therefore keeps a full behavioural copy of every stack and compares the response on every request and the handshake on every cycle. Long random runs confined to four sets make a wrong order or owner surface within a few requests. A fault in the state machine shows within the same request as a missing or mistimed `rsp_valid` or `req_ready`.

// File: rtl/shlru_pkg.sv
package shlru_pkg;
    localparam int WAYS  = 16;
    localparam int WAY_W = $clog2(WAYS);
    localparam int TIDS  = 4;
    localparam int TID_W = $clog2(TIDS);
    localparam int CNT_W = $clog2(WAYS + 2);

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [WAY_W-1:0] way;
    } slot_t;

    // index 0 = most recent, WAYS-1 = least recent
    typedef slot_t [WAYS-1:0] stack_t;

    typedef enum logic [1:0] {
        RSN_HIT      = 2'b00,
        RSN_INVALID  = 2'b01,
        RSN_INACTIVE = 2'b10,
        RSN_MAJORITY = 2'b11
    } reason_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHOOSE,
        ST_COMMIT
    } state_e;
endpackage

// File: rtl/shlru_tid_scan.sv
module shlru_tid_scan
    import shlru_pkg::*;
(
    input  stack_t                       stk,
    output logic [TIDS-1:0]              present,
    output logic [TIDS-1:0][WAY_W-1:0]   lru_pos,
    output logic [TIDS-1:0][CNT_W-1:0]   resident_cnt
);
    for (genvar t = 0; t < TIDS; t++) begin : g_tid
        logic [WAYS-1:0] match;
        always_comb begin
            for (int i = 0; i < WAYS; i++) begin
                match[i] = (stk[i].tid == TID_W'(t));
            end
        end
        // priority toward the least-recent end: the last match wins
        always_comb begin
            present[t]      = 1'b0;
            lru_pos[t]      = '0;
            resident_cnt[t] = '0;
            for (int i = 0; i < WAYS; i++) begin
                if (match[i]) begin
                    present[t]      = 1'b1;
                    lru_pos[t]      = WAY_W'(i);
                    resident_cnt[t] = resident_cnt[t] + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/shlru_pick.sv
module shlru_pick
    import shlru_pkg::*;
(
    input  stack_t                       stk,
    input  logic [WAYS-1:0]              way_valid,
    input  logic [TIDS-1:0]              tid_inactive,
    input  logic [TID_W-1:0]             req_tid,
    input  logic [TIDS-1:0]              present,
    input  logic [TIDS-1:0][WAY_W-1:0]   lru_pos,
    input  logic [TIDS-1:0][CNT_W-1:0]   resident_cnt,
    output logic [WAY_W-1:0]             vict_way,
    output logic [TID_W-1:0]             vict_owner,
    output reason_e                      vict_reason
);
    logic             any_inv;
    logic [WAY_W-1:0] inv_way;
    logic [TID_W-1:0] inv_owner;
    logic             ia_found;
    logic [WAY_W-1:0] ia_pos;
    logic             best_found;
    logic [TID_W-1:0] best_tid;
    logic [CNT_W-1:0] best_cnt;
    logic [WAY_W-1:0] best_pos;
    logic [CNT_W-1:0] cand_cnt;

    // lowest-indexed invalid way and its recorded owner
    always_comb begin
        any_inv = ~&way_valid;
        inv_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) inv_way = WAY_W'(i);
        end
        inv_owner = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (stk[i].way == inv_way) inv_owner = stk[i].tid;
        end
    end

    // inactive-owned block nearest the least-recent end
    always_comb begin
        ia_found = 1'b0;
        ia_pos   = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (tid_inactive[stk[i].tid]) begin
                ia_found = 1'b1;
                ia_pos   = WAY_W'(i);
            end
        end
    end

    // largest occupancy including the incoming block; tie -> nearest LRU
    always_comb begin
        best_found = 1'b0;
        best_tid   = '0;
        best_cnt   = '0;
        best_pos   = '0;
        cand_cnt   = '0;
        for (int t = 0; t < TIDS; t++) begin
            cand_cnt = resident_cnt[t] + CNT_W'(req_tid == TID_W'(t));
            if (present[t]) begin
                if (!best_found || (cand_cnt > best_cnt) ||
                    ((cand_cnt == best_cnt) && (lru_pos[t] > best_pos))) begin
                    best_found = 1'b1;
                    best_tid   = TID_W'(t);
                    best_cnt   = cand_cnt;
                    best_pos   = lru_pos[t];
                end
            end
        end
    end

    always_comb begin
        if (any_inv) begin
            vict_way    = inv_way;
            vict_owner  = inv_owner;
            vict_reason = RSN_INVALID;
        end else if (ia_found) begin
            vict_way    = stk[ia_pos].way;
            vict_owner  = stk[ia_pos].tid;
            vict_reason = RSN_INACTIVE;
        end else begin
            vict_way    = stk[best_pos].way;
            vict_owner  = best_tid;
            vict_reason = RSN_MAJORITY;
        end
    end
endmodule

// File: rtl/shlru_promote.sv
module shlru_promote
    import shlru_pkg::*;
(
    input  stack_t           stk,
    input  logic [WAY_W-1:0] tgt_way,
    input  logic [TID_W-1:0] new_tid,
    input  logic             rewrite_tid,
    output stack_t           stk_nxt,
    output logic [TID_W-1:0] tgt_owner
);
    logic [WAY_W-1:0] hit_pos;

    always_comb begin
        hit_pos = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (stk[i].way == tgt_way) hit_pos = WAY_W'(i);
        end
        tgt_owner = stk[hit_pos].tid;
    end

    always_comb begin
        stk_nxt[0].way = tgt_way;
        stk_nxt[0].tid = rewrite_tid ? new_tid : tgt_owner;
        for (int i = 1; i < WAYS; i++) begin
            if (i <= int'(hit_pos)) stk_nxt[i] = stk[i-1];
            else                    stk_nxt[i] = stk[i];
        end
    end
endmodule

// File: rtl/shlru_victim_sel.sv
module shlru_victim_sel
    import shlru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [SET_W-1:0]     req_set,
    input  logic                 req_hit,
    input  logic [WAY_W-1:0]     req_way,
    input  logic [TID_W-1:0]     req_tid,
    input  logic [WAYS-1:0]      way_valid,
    input  logic [TIDS-1:0]      tid_inactive,
    output logic                 rsp_valid,
    output logic [WAY_W-1:0]     rsp_way,
    output logic [TID_W-1:0]     rsp_tid,
    output logic [1:0]           rsp_reason
);
    state_e state, state_nxt;

    stack_t stk_mem [NUM_SETS];
    stack_t cur_stk;
    stack_t nxt_stk_q;

    logic [SET_W-1:0] q_set;
    logic             q_hit;
    logic [WAY_W-1:0] q_way;
    logic [TID_W-1:0] q_tid;
    logic [WAYS-1:0]  q_valid;
    logic [TIDS-1:0]  q_inactive;

    logic [WAY_W-1:0] rsp_way_q;
    logic [TID_W-1:0] rsp_tid_q;
    reason_e          rsp_reason_q;

    logic [TIDS-1:0]            sc_present;
    logic [TIDS-1:0][WAY_W-1:0] sc_lru_pos;
    logic [TIDS-1:0][CNT_W-1:0] sc_cnt;
    logic [WAY_W-1:0]           pk_way;
    logic [TID_W-1:0]           pk_owner;
    reason_e                    pk_reason;
    logic [WAY_W-1:0]           tgt_way;
    stack_t                     promo_stk;
    logic [TID_W-1:0]           promo_owner;

    shlru_tid_scan u_scan (
        .stk          (cur_stk),
        .present      (sc_present),
        .lru_pos      (sc_lru_pos),
        .resident_cnt (sc_cnt)
    );

    shlru_pick u_pick (
        .stk          (cur_stk),
        .way_valid    (q_valid),
        .tid_inactive (q_inactive),
        .req_tid      (q_tid),
        .present      (sc_present),
        .lru_pos      (sc_lru_pos),
        .resident_cnt (sc_cnt),
        .vict_way     (pk_way),
        .vict_owner   (pk_owner),
        .vict_reason  (pk_reason)
    );

    assign tgt_way = q_hit ? q_way : pk_way;

    shlru_promote u_promote (
        .stk         (cur_stk),
        .tgt_way     (tgt_way),
        .new_tid     (q_tid),
        .rewrite_tid (!q_hit),
        .stk_nxt     (promo_stk),
        .tgt_owner   (promo_owner)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nxt = ST_LOAD;
            ST_LOAD:   state_nxt = ST_CHOOSE;
            ST_CHOOSE: state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        rsp_valid  = (state == ST_COMMIT);
        rsp_way    = rsp_way_q;
        rsp_tid    = rsp_tid_q;
        rsp_reason = rsp_reason_q;
    end

    // datapath and stack storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int i = 0; i < WAYS; i++) begin
                    stk_mem[s][i].way <= WAY_W'(i);
                    stk_mem[s][i].tid <= '0;
                end
            end
            cur_stk      <= '0;
            nxt_stk_q    <= '0;
            q_set        <= '0;
            q_hit        <= 1'b0;
            q_way        <= '0;
            q_tid        <= '0;
            q_valid      <= '0;
            q_inactive   <= '0;
            rsp_way_q    <= '0;
            rsp_tid_q    <= '0;
            rsp_reason_q <= RSN_HIT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_set      <= req_set;
                        q_hit      <= req_hit;
                        q_way      <= req_way;
                        q_tid      <= req_tid;
                        q_valid    <= way_valid;
                        q_inactive <= tid_inactive;
                    end
                end
                ST_LOAD: begin
                    cur_stk <= stk_mem[q_set];
                end
                ST_CHOOSE: begin
                    nxt_stk_q    <= promo_stk;
                    rsp_way_q    <= tgt_way;
                    rsp_tid_q    <= q_hit ? promo_owner : pk_owner;
                    rsp_reason_q <= q_hit ? RSN_HIT : pk_reason;
                end
                ST_COMMIT: begin
                    stk_mem[q_set] <= nxt_stk_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/shlru_victim_sel_chk.sv
module shlru_victim_sel_chk
    import shlru_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_hit,
    input logic [WAY_W-1:0]  req_way,
    input logic [WAYS-1:0]   way_valid,
    input logic [TIDS-1:0]   tid_inactive,
    input logic              rsp_valid,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [TID_W-1:0]  rsp_tid,
    input logic [1:0]        rsp_reason
);
    logic             c_hit;
    logic [WAY_W-1:0] c_way;
    logic [WAYS-1:0]  c_valid;
    logic [TIDS-1:0]  c_inactive;
    logic [WAYS-1:0]  below;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_hit      <= 1'b0;
            c_way      <= '0;
            c_valid    <= '1;
            c_inactive <= '0;
        end else if (req_valid && req_ready) begin
            c_hit      <= req_hit;
            c_way      <= req_way;
            c_valid    <= way_valid;
            c_inactive <= tid_inactive;
        end
    end

    assign below = (WAYS'(1) << rsp_way) - WAYS'(1);

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R2
    AST_HIT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && c_hit) |-> (rsp_way == c_way && rsp_reason == 2'b00)); // R3
    AST_INVALID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !c_hit && !(&c_valid)) |->
        (rsp_reason == 2'b01 && !c_valid[rsp_way] && ((~c_valid & below) == '0))); // R4
    AST_INACTIVE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_reason == 2'b10) |->
        (c_inactive[rsp_tid] && (&c_valid) && !c_hit)); // R5
    AST_MAJORITY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_reason == 2'b11) |-> !c_inactive[rsp_tid]); // R6
endmodule

bind shlru_victim_sel shlru_victim_sel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_hit      (req_hit),
    .req_way      (req_way),
    .way_valid    (way_valid),
    .tid_inactive (tid_inactive),
    .rsp_valid    (rsp_valid),
    .rsp_way      (rsp_way),
    .rsp_tid      (rsp_tid),
    .rsp_reason   (rsp_reason)
);

// File: tb/shlru_victim_sel_test.sv
module shlru_victim_sel_test;
    localparam int NSETS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_set = '0;
    logic        req_hit = 1'b0;
    logic [3:0]  req_way = '0;
    logic [1:0]  req_tid = '0;
    logic [15:0] way_valid = '1;
    logic [3:0]  tid_inactive = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_way;
    logic [1:0]  rsp_tid;
    logic [1:0]  rsp_reason;

    int total = 0;
    int fails = 0;
    bit done = 0;

    int m_way [NSETS][16];
    int m_tid [NSETS][16];
    int lfsr = 32'h1ace_b00c;

    always #2 clk = ~clk;

    shlru_victim_sel uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_hit(req_hit), .req_way(req_way), .req_tid(req_tid),
        .way_valid(way_valid), .tid_inactive(tid_inactive), .rsp_valid(rsp_valid),
        .rsp_way(rsp_way), .rsp_tid(rsp_tid), .rsp_reason(rsp_reason)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rnd();
        lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
        return lfsr & 32'h7fff_ffff;
    endfunction

    // requests start and end on a falling edge
    task automatic do_req(input int s, input bit hit, input int way, input int tid,
                          input logic [15:0] vld, input logic [3:0] inact, input string tag);
        int e_way, e_tid, e_rsn, new_tid, pos;
        int cnt[4];
        int lp[4];
        int best;
        bit tie;
        int qw[$];
        int qt[$];
        string lbl;
        e_way = 0; e_tid = 0; e_rsn = 0; best = -1; tie = 0;
        if (hit) begin
            e_way = way; e_rsn = 0; lbl = "R3";
        end else if (vld != 16'hffff) begin
            for (int w = 15; w >= 0; w--) if (!vld[w]) e_way = w;
            e_rsn = 1; lbl = "R4";
        end else begin
            pos = -1;
            for (int i = 15; i >= 0; i--)
                if (pos < 0 && inact[m_tid[s][i]]) pos = i;
            if (pos >= 0) begin
                e_way = m_way[s][pos]; e_rsn = 2; lbl = "R5";
            end else begin
                for (int t = 0; t < 4; t++) begin cnt[t] = (t == tid) ? 1 : 0; lp[t] = -1; end
                for (int i = 0; i < 16; i++) begin cnt[m_tid[s][i]]++; lp[m_tid[s][i]] = i; end
                for (int t = 0; t < 4; t++) begin
                    if (lp[t] >= 0) begin
                        if (best < 0 || cnt[t] > cnt[best]) begin best = t; tie = 0; end
                        else if (cnt[t] == cnt[best]) begin
                            tie = 1;
                            if (lp[t] > lp[best]) best = t;
                        end
                    end
                end
                // recheck tie against final winner
                tie = 0;
                for (int t = 0; t < 4; t++)
                    if (t != best && lp[t] >= 0 && cnt[t] == cnt[best]) tie = 1;
                e_way = m_way[s][lp[best]]; e_rsn = 3; lbl = tie ? "R7" : "R6";
            end
        end
        pos = 0;
        for (int i = 0; i < 16; i++) if (m_way[s][i] == e_way) pos = i;
        e_tid = m_tid[s][pos];
        if (tag != "") lbl = tag;
        new_tid = hit ? e_tid : tid;

        check(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        req_set = 4'(s); req_hit = hit; req_way = 4'(way); req_tid = 2'(tid);
        way_valid = vld; tid_inactive = inact; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b0 && req_ready == 1'b0, "R2 cycle1", int'({rsp_valid, req_ready}), 0);
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b0, "R2 cycle2", int'({rsp_valid, req_ready}), 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 response valid", int'(rsp_valid), 1);
        check(int'(rsp_way) == e_way, {lbl, " way"}, int'(rsp_way), e_way);
        check(int'(rsp_tid) == e_tid, {lbl, " owner"}, int'(rsp_tid), e_tid);
        check(int'(rsp_reason) == e_rsn, {lbl, " reason"}, int'(rsp_reason), e_rsn);
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R2 back to idle",
              int'({rsp_valid, req_ready}), 1);

        // R8 model update: chosen way to most recent
        for (int i = 0; i < 16; i++) begin qw.push_back(m_way[s][i]); qt.push_back(m_tid[s][i]); end
        qw.delete(pos); qt.delete(pos);
        qw.push_front(e_way); qt.push_front(new_tid);
        for (int i = 0; i < 16; i++) begin m_way[s][i] = qw[i]; m_tid[s][i] = qt[i]; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int i = 0; i < 16; i++) begin m_way[s][i] = i; m_tid[s][i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

        do_req(0, 0, 0, 1, 16'hffff, 4'h0, "R1");
        do_req(1, 0, 0, 2, 16'hffff, 4'h0, "R9");
        do_req(0, 1, 3, 2, 16'hffff, 4'h0, "");
        do_req(0, 0, 0, 3, 16'hfdff & 16'hffdf, 4'h0, "");
        do_req(0, 0, 0, 3, 16'hfffe, 4'h0, "");
        // inactive bit of a thread with no blocks in set 2 is ignored
        do_req(2, 0, 0, 1, 16'hffff, 4'h8, "R5 ignored mask");
        // fill rewrites owner: only thread-2 block in set 5 is the fresh fill
        do_req(5, 0, 0, 2, 16'hffff, 4'h0, "");
        do_req(5, 0, 0, 3, 16'hffff, 4'h4, "R8");
        do_req(0, 0, 0, 1, 16'hffff, 4'h1, "");

        // build an even split in set 3, then tie cases
        for (int k = 0; k < 8; k++) do_req(3, 0, 0, 1, 16'hffff, 4'h0, "");
        do_req(3, 0, 0, 2, 16'hffff, 4'h0, "R7");
        for (int k = 0; k < 16; k++)
            if (m_tid[3][k] == 0) do_req(3, 1, m_way[3][k], 0, 16'hffff, 4'h0, "");
        do_req(3, 0, 0, 3, 16'hffff, 4'h0, "");

        for (int n = 0; n < 400; n++) begin
            int s, r, v, ia;
            logic [15:0] vm;
            logic [3:0] im;
            s = rnd() % 4;
            r = rnd();
            vm = 16'hffff;
            im = 4'h0;
            v = rnd() % 8;
            if (v == 0) vm[rnd() % 16] = 1'b0;
            if (v == 1) begin vm[rnd() % 16] = 1'b0; vm[rnd() % 16] = 1'b0; end
            ia = rnd() % 6;
            if (ia == 0) im[rnd() % 4] = 1'b1;
            do_req(s, (r % 3) == 0, rnd() % 16, rnd() % 4, vm, im, "");
        end
        finish_run();
    end
endmodule